// File: doc/BRIEF.md
# Rotated-Immediate Encoder with Paired-Opcode Fallback

This block takes a 32-bit constant and a data-processing opcode and works out whether the constant fits the short immediate form. That form is an 8-bit value rotated right within a 32-bit word by twice a 4-bit rotate field. If the constant does not fit but the paired opcode can carry it, the block switches to that opcode. The paired opcode takes the two's-complement negation of the constant or its bitwise inverse, depending on the pair. A code generator or assembler back end uses it to pick the final opcode and immediate fields for one instruction.

A request is one cycle with `req_i` high. One cycle later `done_o` pulses, and the registered result appears on the outputs. The result stays on the outputs until the next request. Among several rotations that fit, the search takes the smallest rotate field. A direct fit always takes priority over a substitution.

Top module: `imm_rot_encoder`

## Requirements
- R1: While reset is asserted, and after it is released, every output is zero until the first request.
- R2: `done_o` is high in exactly the cycle after a cycle with `req_i` high, and low otherwise. When no request is made, every result output holds its value.
- R3: If the constant fits directly, the block sets `valid_o`=1, `subst_o`=0 and `op_o`=`op_i`. The constant then equals `imm_o` rotated right by 2*`rot_o` within 32 bits.
- R4: When several rotate fields fit, the smallest is chosen. For example, 1020 gives imm 0xFF with rot 15, 0x00000004 gives imm 4 with rot 0, and 0 gives imm 0 with rot 0.
- R5: If both the direct constant and its transformed form fit, the direct encoding is produced.
- R6: Opcode codes are ADD=0, SUB=1, ADC=2, SBC=3, AND=4, BIC=5, MOV=6, MVN=7, CMP=8, CMN=9. The partner of a code is the code with bit 0 flipped.
- R7: For ADD, SUB, CMP and CMN, the fallback works as follows when the constant does not fit. If its two's-complement negation fits, the block outputs the partner opcode with `subst_o`=1 and encodes the negated value.
- R8: For ADC, SBC, AND, BIC, MOV and MVN, the fallback works as follows when the constant does not fit. If its bitwise inverse fits, the block outputs the partner opcode with `subst_o`=1 and encodes the inverted value.
- R9: If neither form fits, `valid_o`=0 and `op_o`, `imm_o`, `rot_o` and `subst_o` are all zero. `done_o` still pulses.
- R10: Opcode codes 10 to 15 are unsupported. They give the R9 all-zero invalid result whatever the constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; captures op_i and const_i |
| op_i | input | 4 | Requested opcode code |
| const_i | input | 32 | Constant to encode |
| done_o | output | 1 | Result-ready pulse, one cycle after req_i |
| valid_o | output | 1 | An encoding was found |
| op_o | output | 4 | Final opcode (possibly the partner) |
| imm_o | output | 8 | 8-bit immediate value |
| rot_o | output | 4 | Rotate field; rotation is 2*rot_o to the right |
| subst_o | output | 1 | The partner opcode was used |

## Verification
The block holds only one result register, so any fault in the search or the pair map shows up on the outputs of the very next result. A wrong rotation priority shows as a larger `rot_o` than the reference. A wrong transform shows as an immediate that does not expand to the negated or inverted constant. A wrong partner shows in `op_o`. The sweep forms direct, negated, inverted and unencodable constants for every opcode code, so each of these faults is visible within one request.

// File: rtl/imm_enc_pkg.sv
package imm_enc_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1,
    OP_ADC = 4'd2, OP_SBC = 4'd3,
    OP_AND = 4'd4, OP_BIC = 4'd5,
    OP_MOV = 4'd6, OP_MVN = 4'd7,
    OP_CMP = 4'd8, OP_CMN = 4'd9
  } dp_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd9;
endpackage

// File: rtl/rot_fit_search.sv
module rot_fit_search #(
  parameter int WORD_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [ROT_W-1:0]  rot_o
);
  localparam int N_ROT = 1 << ROT_W;
  localparam int STEP  = WORD_W / N_ROT;

  logic [2*WORD_W-1:0] dbl;
  logic [N_ROT-1:0]    fit;
  logic [IMM_W-1:0]    cand [N_ROT];

  assign dbl = {word_i, word_i};

  // Each slot undoes one rotation: rotate left and require the high part clear.
  for (genvar r = 0; r < N_ROT; r++) begin : g_slot
    localparam int SH = r * STEP;
    logic [WORD_W-1:0] back;
    assign back    = dbl[2*WORD_W-1-SH -: WORD_W];
    assign fit[r]  = (back[WORD_W-1:IMM_W] == '0);
    assign cand[r] = back[IMM_W-1:0];
  end

  // Walk downward so the smallest fitting slot is the last one written.
  always_comb begin
    hit_o = 1'b0;
    imm_o = '0;
    rot_o = '0;
    for (int r = N_ROT - 1; r >= 0; r--) begin
      if (fit[r]) begin
        hit_o = 1'b1;
        imm_o = cand[r];
        rot_o = ROT_W'(r);
      end
    end
  end

  // R3: a reported fit must expand back to the searched word
  logic [2*WORD_W-1:0] exp_dbl;
  logic [WORD_W-1:0]   expanded;
  always_comb begin
    exp_dbl  = {{(WORD_W-IMM_W){1'b0}}, imm_o, {(WORD_W-IMM_W){1'b0}}, imm_o};
    expanded = WORD_W'(exp_dbl >> (int'(rot_o) * STEP));
    if (hit_o) begin
      fit_expands_chk: assert (expanded == word_i)
        else $error("search result does not expand to input word");
    end
  end
endmodule

// File: rtl/op_pair_map.sv
module op_pair_map
  import imm_enc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              known_o,
  output logic [OP_W-1:0]   partner_o,
  output logic [WORD_W-1:0] alt_o
);
  logic use_neg;

  assign known_o   = (op_i <= OP_LAST);
  assign partner_o = op_i ^ OP_W'(1);

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB, OP_CMP, OP_CMN: use_neg = 1'b1;
      default:                        use_neg = 1'b0;
    endcase
  end

  assign alt_o = use_neg ? (~word_i + WORD_W'(1)) : ~word_i;
endmodule

// File: rtl/imm_rot_encoder.sv
module imm_rot_encoder
  import imm_enc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] const_i,
  output logic              done_o,
  output logic              valid_o,
  output logic [OP_W-1:0]   op_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [ROT_W-1:0]  rot_o,
  output logic              subst_o
);
  localparam int STEP = WORD_W / (1 << ROT_W);

  // Reset asserts at once and releases on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic              known;
  logic [OP_W-1:0]   partner;
  logic [WORD_W-1:0] alt_word;
  logic              hit_d, hit_a;
  logic [IMM_W-1:0]  imm_d, imm_a;
  logic [ROT_W-1:0]  rot_d, rot_a;

  op_pair_map #(.WORD_W(WORD_W)) u_map (
    .op_i(op_i), .word_i(const_i),
    .known_o(known), .partner_o(partner), .alt_o(alt_word)
  );

  rot_fit_search #(.WORD_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_direct (
    .word_i(const_i), .hit_o(hit_d), .imm_o(imm_d), .rot_o(rot_d)
  );

  rot_fit_search #(.WORD_W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_alt (
    .word_i(alt_word), .hit_o(hit_a), .imm_o(imm_a), .rot_o(rot_a)
  );

  logic             valid_n, subst_n;
  logic [OP_W-1:0]  op_n;
  logic [IMM_W-1:0] imm_n;
  logic [ROT_W-1:0] rot_n;

  always_comb begin
    valid_n = 1'b0;
    subst_n = 1'b0;
    op_n    = '0;
    imm_n   = '0;
    rot_n   = '0;
    if (known && hit_d) begin
      valid_n = 1'b1;
      op_n    = op_i;
      imm_n   = imm_d;
      rot_n   = rot_d;
    end else if (known && hit_a) begin
      valid_n = 1'b1;
      subst_n = 1'b1;
      op_n    = partner;
      imm_n   = imm_a;
      rot_n   = rot_a;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      subst_o <= 1'b0;
      op_o    <= '0;
      imm_o   <= '0;
      rot_o   <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        valid_o <= valid_n;
        subst_o <= subst_n;
        op_o    <= op_n;
        imm_o   <= imm_n;
        rot_o   <= rot_n;
      end
    end
  end

  // R2
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_i |=> done_o);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_i |=> !done_o);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_i |=> ($stable(valid_o) && $stable(op_o) && $stable(imm_o)
                && $stable(rot_o) && $stable(subst_o)));
  // R9
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !valid_o |-> (op_o == '0 && imm_o == '0 && rot_o == '0 && !subst_o));
  // R6
  subst_partner_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_i |=> (!subst_o || op_o == ($past(op_i) ^ OP_W'(1))));
  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_i && op_i > OP_LAST) |=> !valid_o);

  // R3
  logic [2*WORD_W-1:0] out_dbl;
  logic [WORD_W-1:0]   out_word;
  assign out_dbl  = {{(WORD_W-IMM_W){1'b0}}, imm_o, {(WORD_W-IMM_W){1'b0}}, imm_o};
  assign out_word = WORD_W'(out_dbl >> (int'(rot_o) * STEP));
  direct_expand_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_i |=> (!valid_o || subst_o || out_word == $past(const_i)));
endmodule

// File: tb/tb_imm_rot_encoder.sv
module tb_imm_rot_encoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [3:0]  op_i;
  logic [31:0] const_i;
  logic        done_o, valid_o, subst_o;
  logic [3:0]  op_o, rot_o;
  logic [7:0]  imm_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  imm_rot_encoder dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i), .const_i(const_i),
    .done_o(done_o), .valid_o(valid_o), .op_o(op_o), .imm_o(imm_o),
    .rot_o(rot_o), .subst_o(subst_o)
  );

  function automatic logic [31:0] rotr32(input logic [31:0] v, input int n);
    if (n % 32 == 0) return v;
    return (v >> (n % 32)) | (v << (32 - n % 32));
  endfunction

  // Reference: try each rotate field in ascending order.
  function automatic bit fits(input logic [31:0] k, output logic [7:0] v,
                              output logic [3:0] r);
    for (int f = 0; f < 16; f++) begin
      for (int b = 0; b < 256; b += 1) begin
        if (rotr32(32'(b), 2*f) == k) begin
          v = 8'(b); r = 4'(f); return 1'b1;
        end
      end
    end
    v = 0; r = 0; return 1'b0;
  endfunction

  task automatic check(input string tag, input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic run_one(input logic [3:0] op, input logic [31:0] k);
    logic [7:0] ev; logic [3:0] er, eop; bit ev_ok, esub;
    logic [31:0] alt, target; string tag;
    logic [7:0] av; logic [3:0] ar;
    bit neg;
    neg = (op == 0 || op == 1 || op == 8 || op == 9);
    alt = neg ? (~k + 32'd1) : ~k;
    ev_ok = 0; esub = 0; eop = 0; ev = 0; er = 0; target = 0;
    if (op > 9) tag = "R10";
    else if (fits(k, ev, er)) begin
      ev_ok = 1; eop = op; target = k; tag = "R3";
    end else if (fits(alt, av, ar)) begin
      ev_ok = 1; esub = 1; eop = op ^ 4'd1; ev = av; er = ar; target = alt;
      tag = neg ? "R7" : "R8";
    end else tag = "R9";
    @(negedge clk);
    req_i = 1'b1; op_i = op; const_i = k;
    @(negedge clk);
    req_i = 1'b0;
    check(tag, done_o && valid_o == ev_ok && subst_o == esub && op_o == eop
               && imm_o == ev && rot_o == er,
      $sformatf("op=%0d k=%h got v%0b s%0b op%0d imm%h rot%0d exp v%0b s%0b op%0d imm%h rot%0d",
        op, k, valid_o, subst_o, op_o, imm_o, rot_o, ev_ok, esub, eop, ev, er));
    if (ev_ok)
      check(tag, rotr32(32'(imm_o), 2*int'(rot_o)) == target,
        $sformatf("expansion got %h exp %h", rotr32(32'(imm_o), 2*int'(rot_o)), target));
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] snap_imm; logic [3:0] snap_rot;
    rst_n = 1'b0; req_i = 1'b0; op_i = 0; const_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {done_o, valid_o, subst_o, op_o, imm_o, rot_o} == '0,
      $sformatf("reset outputs got %b exp 0", {done_o, valid_o, subst_o, op_o, imm_o, rot_o}));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {done_o, valid_o, subst_o, op_o, imm_o, rot_o} == '0,
      "post-reset outputs not zero, exp 0");

    // R4 smallest rotate field, named corners
    run_one(4'd0, 32'd1020);
    check("R4", imm_o == 8'hFF && rot_o == 4'd15, $sformatf("1020 got %h/%0d exp ff/15", imm_o, rot_o));
    run_one(4'd6, 32'h4);
    check("R4", imm_o == 8'h4 && rot_o == 4'd0, $sformatf("4 got %h/%0d exp 04/0", imm_o, rot_o));
    run_one(4'd4, 32'h0);
    check("R4", valid_o && imm_o == 0 && rot_o == 0, "zero constant not imm 0 rot 0");
    // R5 both forms fit: direct wins
    run_one(4'd0, 32'h8000_0000);
    check("R5", valid_o && !subst_o && op_o == 4'd0, $sformatf("got s%0b op%0d exp s0 op0", subst_o, op_o));
    // R7 negation: ADD #-1 -> SUB #1 ; CMP -> CMN
    run_one(4'd0, 32'hFFFF_FFFF);
    check("R7", subst_o && op_o == 4'd1 && imm_o == 8'd1, $sformatf("got op%0d imm%h exp op1 imm01", op_o, imm_o));
    run_one(4'd8, 32'hFFFF_FF00);
    check("R7", subst_o && op_o == 4'd9 && imm_o == 8'h1 && rot_o == 4'd12,
      $sformatf("got op%0d imm%h rot%0d exp op9 imm01 rot12", op_o, imm_o, rot_o));
    // R8 inversion: MOV -> MVN ; SBC -> ADC
    run_one(4'd6, 32'hFFFF_FF00);
    check("R8", subst_o && op_o == 4'd7 && imm_o == 8'hFF && rot_o == 0,
      $sformatf("got op%0d imm%h exp op7 immff", op_o, imm_o));
    run_one(4'd3, 32'hFFFF_FFFE);
    check("R6", op_o == 4'd2 && imm_o == 8'h1, $sformatf("got op%0d imm%h exp op2 imm01", op_o, imm_o));
    // R9 unencodable
    run_one(4'd4, 32'h0001_0101);
    check("R9", done_o && !valid_o && op_o == 0, "unencodable not invalid");
    // R10 unsupported opcode
    run_one(4'd12, 32'h0000_00FF);
    check("R10", !valid_o && op_o == 0 && imm_o == 0, "bad opcode produced a result");

    // R2 idle cycle: done low, outputs held
    run_one(4'd2, 32'h0000_3F00);
    snap_imm = imm_o; snap_rot = rot_o;
    const_i = 32'hDEAD_BEEF; op_i = 4'd5;
    @(negedge clk);
    check("R2", !done_o && imm_o == snap_imm && rot_o == snap_rot && valid_o,
      $sformatf("idle got done%0b imm%h exp done0 imm%h", done_o, imm_o, snap_imm));

    // Sweep: every opcode code, many encodable seeds and their transforms.
    for (int op = 0; op < 16; op++) begin
      for (int rf = 0; rf < 16; rf++) begin
        for (int s = 0; s < 5; s++) begin
          logic [7:0] seed;
          logic [31:0] k;
          case (s)
            0: seed = 8'h01; 1: seed = 8'h80; 2: seed = 8'hFF;
            3: seed = 8'h81; default: seed = 8'h3C;
          endcase
          k = rotr32(32'(seed), 2*rf);
          run_one(4'(op), k);
          run_one(4'(op), ~k);
          run_one(4'(op), ~k + 32'd1);
          run_one(4'(op), k ^ 32'h0100_0010);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule